// File: doc/BRIEF.md
# Digital First-Order Phase-Locked-Loop Core

This core holds everything a first-order all-digital phase-locked loop needs except the frequency divider in the feedback path. It has two phase comparators that run side by side. The first is an exclusive-OR of the reference and feedback inputs. The second is an edge-triggered set/clear flag. A select input chooses which comparator output drives the loop filter.

The loop filter is an up/down modulus counter clocked by the K-clock. Its length is chosen at run time by a 4-bit code, so the loop bandwidth and the lock time can be retuned while the loop runs. When the counter wraps, it emits a carry or borrow pulse one K-clock wide. A pulse-adding counter on the I/D-clock turns those pulses into phase steps of its square-wave output. That output leaves the core, passes through an external divide-by-N and returns as the feedback input.

A short code gives a wide capture range and a fast lock. A long code filters phase noise more heavily and locks slowly.

Top module: `dpll_core`

## Requirements
- R1: While `rst` is high at a clock edge, `carry`, `borrow`, `xor_pd`, `edge_pd` and `id_out` all read 0 after that edge.
- R2: With `len_code` = 0 the filter counter holds its value and never raises `carry` or `borrow`.
- R3: With `len_code` = c in 1..15 and the selected comparator output low, the counter counts up, and successive `carry` pulses are exactly 2^(c+2) K-clock cycles apart.
- R4: With the selected comparator output high, the counter counts down, and successive `borrow` pulses are exactly 2^(c+2) K-clock cycles apart.
- R5: `carry` and `borrow` are each high for one K-clock cycle at a time and are never high together.
- R6: When `len_code` changes while counting, the counter continues from its value reduced to the new length. The first wrap comes within 2^(c+2) cycles of the new code, and the regular spacing resumes after it.
- R7: With no corrections, `id_out` is a square wave that is high for 2 I/D-clock cycles and low for 2.
- R8: Each carry advances `id_out` by one I/D-clock cycle, and each borrow delays it by one. At most one correction is applied per `id_out` period.
- R9: `xor_pd` equals `ref_in` XOR `fb_in`, seen three K-clock edges after the inputs settle. `det_sel` = 0 routes it to the filter.
- R10: `edge_pd` is set by a rising edge of `fb_in` and cleared by a rising edge of `ref_in`. If both edges arrive in the same cycle, the flag clears. `det_sel` = 1 routes it to the filter.
- R11: In a closed loop with a divide-by-32 feedback and a 50%-duty reference of period 126 clocks, code 1 locks with either comparator. Locked means the span of eight feedback periods is within 6 clocks of 1008.
- R12: Under the same loop conditions, lock takes longer at code 15 than at code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kclk | input | 1 | Filter-counter and comparator clock |
| idclk | input | 1 | Pulse-adding counter clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference signal |
| fb_in | input | 1 | Feedback from the external divider |
| len_code | input | 4 | Filter length code (0 = off, c = c+2 stages) |
| det_sel | input | 1 | Comparator select: 0 exclusive-OR, 1 edge flag |
| xor_pd | output | 1 | Exclusive-OR comparator result |
| edge_pd | output | 1 | Edge-triggered comparator result |
| carry | output | 1 | Filter counter wrapped upward |
| borrow | output | 1 | Filter counter wrapped downward |
| id_out | output | 1 | Corrected loop output |

## Verification
A wrong counter length or a stale high-order bit left after a code change shows up as a carry or borrow spacing other than 2^(c+2). That is visible within one counter period of the change. A lost or duplicated correction in the pulse-adding stage changes how many `id_out` edges fall in a fixed window, and this drifts by one edge within a few hundred cycles. A comparator with the wrong polarity or the wrong tie rule shows at its output three edges after the stimulus. In the closed loop it keeps the feedback slipping, so the eight-period span never settles.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
   // Width of the filter length code.
   localparam int CODE_W    = 4;
   // Stages added to the code value to get the counter length.
   localparam int STAGE_OFS = 2;
   // Widest filter counter reached by the largest code.
   localparam int KCNT_W    = (1 << CODE_W) - 1 + STAGE_OFS;
   // Synchronizer depth for inputs that cross into a clock domain.
   localparam int SYNC_N    = 2;
endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dpll_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else if (i == 0) chain[i] <= d;
            else chain[i] <= chain[(i == 0) ? 0 : i - 1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det #(
   parameter int SYNC_STAGES = dpll_pkg::SYNC_N
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_in,
   input  logic fb_in,
   output logic xor_q,
   output logic edge_q
);
   logic [1:0] s_now;
   logic [1:0] s_old;
   logic       ref_rise;
   logic       fb_rise;

   dpll_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d({ref_in, fb_in}), .q(s_now)
   );

   assign ref_rise = s_now[1] & ~s_old[1];
   assign fb_rise  = s_now[0] & ~s_old[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         s_old  <= '0;
         xor_q  <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         s_old <= s_now;
         xor_q <= s_now[1] ^ s_now[0];
         // reference edge wins a tie
         if (ref_rise)     edge_q <= 1'b0;
         else if (fb_rise) edge_q <= 1'b1;
      end
   end

   assert_edge_clear_R10: assert property (@(posedge clk) disable iff (rst)
      ref_rise |=> !edge_q);
endmodule

// File: rtl/dpll_kcounter.sv
module dpll_kcounter #(
   parameter int CODE_W    = dpll_pkg::CODE_W,
   parameter int STAGE_OFS = dpll_pkg::STAGE_OFS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] code,
   input  logic              down,
   output logic              carry,
   output logic              borrow
);
   localparam int CW = (1 << CODE_W) - 1 + STAGE_OFS;

   generate
      if (CODE_W < 1 || CODE_W > 5) begin : g_bad_code
         $error("dpll_kcounter: CODE_W out of range");
      end
      if (STAGE_OFS < 1) begin : g_bad_ofs
         $error("dpll_kcounter: STAGE_OFS must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] mask;
   logic [CW-1:0] cm;

   always_comb begin
      if (code == '0) mask = '0;
      else mask = (CW'(1) << (int'(code) + STAGE_OFS)) - CW'(1);
      cm = cnt & mask;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         carry  <= 1'b0;
         borrow <= 1'b0;
      end else if (code == '0) begin
         carry  <= 1'b0;
         borrow <= 1'b0;
      end else if (down) begin
         carry <= 1'b0;
         if (cm == '0) begin
            cnt    <= mask;
            borrow <= 1'b1;
         end else begin
            cnt    <= cm - CW'(1);
            borrow <= 1'b0;
         end
      end else begin
         borrow <= 1'b0;
         if (cm == mask) begin
            cnt   <= '0;
            carry <= 1'b1;
         end else begin
            cnt   <= cm + CW'(1);
            carry <= 1'b0;
         end
      end
   end

   assert_off_silent_R2: assert property (@(posedge clk) disable iff (rst)
      (code == '0) |=> (!carry && !borrow));
   assert_no_dual_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      !(carry && borrow));
   assert_carry_single_R5: assert property (@(posedge clk) disable iff (rst)
      carry |=> !carry);
   assert_borrow_single_R5: assert property (@(posedge clk) disable iff (rst)
      borrow |=> !borrow);
endmodule

// File: rtl/dpll_idcounter.sv
module dpll_idcounter #(
   parameter int SYNC_STAGES = dpll_pkg::SYNC_N
) (
   input  logic kclk,
   input  logic idclk,
   input  logic rst,
   input  logic carry,
   input  logic borrow,
   output logic id_out
);
   logic       tog_inc, tog_dec;
   logic [1:0] tog_s, tog_p, evt;
   logic [1:0] ph, ph_n;
   logic       done, inc_p, dec_p;
   logic       both, apply_inc, apply_dec, wrap;

   // K-clock side: each pulse flips a level that crosses safely
   always_ff @(posedge kclk) begin
      if (rst) begin
         tog_inc <= 1'b0;
         tog_dec <= 1'b0;
      end else begin
         tog_inc <= tog_inc ^ carry;
         tog_dec <= tog_dec ^ borrow;
      end
   end

   dpll_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(idclk), .rst(rst), .d({tog_inc, tog_dec}), .q(tog_s)
   );

   assign evt = tog_s ^ tog_p;

   always_comb begin
      both      = inc_p & dec_p;
      apply_inc = inc_p & ~dec_p & ~done;
      apply_dec = dec_p & ~inc_p & ~done;
      if (apply_inc)      ph_n = ph + 2'd2;
      else if (apply_dec) ph_n = ph;
      else                ph_n = ph + 2'd1;
      wrap = ph[1] & ~ph_n[1];
   end

   always_ff @(posedge idclk) begin
      if (rst) begin
         tog_p <= '0;
         ph    <= '0;
         done  <= 1'b0;
         inc_p <= 1'b0;
         dec_p <= 1'b0;
      end else begin
         tog_p <= tog_s;
         ph    <= ph_n;
         done  <= (apply_inc | apply_dec) | (done & ~wrap);
         inc_p <= evt[1] | (inc_p & ~(apply_inc | both));
         dec_p <= evt[0] | (dec_p & ~(apply_dec | both));
      end
   end

   assign id_out = ph[1];

   assert_one_fix_R8: assert property (@(posedge idclk) disable iff (rst)
      (apply_inc || apply_dec) |=> !(apply_inc || apply_dec));
endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
   parameter int CODE_W      = dpll_pkg::CODE_W,
   parameter int STAGE_OFS   = dpll_pkg::STAGE_OFS,
   parameter int SYNC_STAGES = dpll_pkg::SYNC_N
) (
   input  logic              kclk,
   input  logic              idclk,
   input  logic              rst,
   input  logic              ref_in,
   input  logic              fb_in,
   input  logic [CODE_W-1:0] len_code,
   input  logic              det_sel,
   output logic              xor_pd,
   output logic              edge_pd,
   output logic              carry,
   output logic              borrow,
   output logic              id_out
);
   logic dir_down;

   dpll_phase_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(kclk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
      .xor_q(xor_pd), .edge_q(edge_pd)
   );

   assign dir_down = det_sel ? edge_pd : xor_pd;

   dpll_kcounter #(.CODE_W(CODE_W), .STAGE_OFS(STAGE_OFS)) u_kcnt (
      .clk(kclk), .rst(rst), .code(len_code), .down(dir_down),
      .carry(carry), .borrow(borrow)
   );

   dpll_idcounter #(.SYNC_STAGES(SYNC_STAGES)) u_idc (
      .kclk(kclk), .idclk(idclk), .rst(rst), .carry(carry),
      .borrow(borrow), .id_out(id_out)
   );
endmodule

// File: tb/sim_dpll_core.sv
`timescale 1ns/1ps
module sim_dpll_core;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst = 1'b1;
   logic       ref_man = 1'b0, fb_man = 1'b0;
   logic       ref_gen, fb_div, id_q;
   logic       loop_en = 1'b0, gen_en = 1'b0;
   logic [3:0] len_code = 4'd0;
   logic       det_sel = 1'b0;
   logic       xor_pd, edge_pd, carry, borrow, id_out;
   int         rcnt, dcnt;
   int         n_chk = 0, n_bad = 0;
   int         cyc = 0;

   wire ref_in = gen_en  ? ref_gen : ref_man;
   wire fb_in  = loop_en ? fb_div  : fb_man;

   dpll_core u0 (
      .kclk(clk), .idclk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
      .len_code(len_code), .det_sel(det_sel), .xor_pd(xor_pd),
      .edge_pd(edge_pd), .carry(carry), .borrow(borrow), .id_out(id_out)
   );

   // reference: 50% duty, period 126 clocks
   always @(negedge clk) begin
      if (rst) begin rcnt <= 0; ref_gen <= 1'b0; end
      else if (rcnt == 62) begin rcnt <= 0; ref_gen <= ~ref_gen; end
      else rcnt <= rcnt + 1;
   end

   // external divide-by-32 on id_out rising edges
   always @(negedge clk) begin
      id_q <= id_out;
      if (rst) begin dcnt <= 0; fb_div <= 1'b0; end
      else if (id_out && !id_q) begin
         if (dcnt == 15) begin dcnt <= 0; fb_div <= ~fb_div; end
         else dcnt <= dcnt + 1;
      end
   end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; loop_en = 1'b0; gen_en = 1'b0; ref_man = 1'b0; fb_man = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst = 1'b1; ref_man = 1'b1; len_code = 4'd1;
      repeat (4) @(negedge clk);
      check({carry, borrow, xor_pd, edge_pd, id_out} == 5'b0, "R1 outputs in reset",
            int'({carry, borrow, xor_pd, edge_pd, id_out}), 0);
      ref_man = 1'b0;
      rst = 1'b0;
   endtask

   // gap in cycles between two consecutive pulses of the chosen output
   task automatic pulse_gap(input bit use_borrow, input int limit, output int gap);
      int t0;
      t0 = -1; gap = -1;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (use_borrow ? borrow : carry) begin
            if (t0 >= 0) begin gap = i - t0; return; end
            t0 = i;
         end
      end
   endtask

   task automatic t_off();
      int hits;
      len_code = 4'd0; det_sel = 1'b0; do_reset();
      hits = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (carry || borrow) hits++;
         if (i == 150) ref_man = 1'b1;
      end
      check(hits == 0, "R2 code 0 silent", hits, 0);
   endtask

   task automatic t_up(input int code);
      int gap;
      len_code = 4'(code); det_sel = 1'b0; do_reset();
      pulse_gap(1'b0, 4 << (code + 2), gap);
      check(gap == (1 << (code + 2)), $sformatf("R3 carry spacing code %0d", code),
            gap, 1 << (code + 2));
   endtask

   task automatic t_down(input int code);
      int gap;
      len_code = 4'(code); det_sel = 1'b0; do_reset();
      ref_man = 1'b1;
      repeat (6) @(negedge clk);
      pulse_gap(1'b1, 4 << (code + 2), gap);
      check(gap == (1 << (code + 2)), $sformatf("R4 borrow spacing code %0d", code),
            gap, 1 << (code + 2));
   endtask

   task automatic t_pulse_shape();
      int wide, dual, run;
      len_code = 4'd1; det_sel = 1'b0; do_reset();
      wide = 0; dual = 0; run = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i == 200) ref_man = 1'b1;
         if (carry && borrow) dual++;
         if (carry || borrow) begin run++; if (run > 1) wide++; end
         else run = 0;
      end
      check(wide == 0, "R5 pulse width one cycle", wide, 0);
      check(dual == 0, "R5 carry and borrow exclusive", dual, 0);
   endtask

   task automatic t_code_change();
      int first, gap;
      len_code = 4'd4; det_sel = 1'b0; do_reset();
      pulse_gap(1'b0, 300, gap);
      repeat (45) @(negedge clk);
      len_code = 4'd1;
      first = -1;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (carry) begin first = i; break; end
      end
      check(first >= 1 && first <= 9, "R6 first wrap after shrink", first, 9);
      gap = 0;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (carry) begin gap = i; break; end
      end
      check(gap == 8, "R6 spacing after shrink", gap, 8);
   endtask

   task automatic count_rises(input int win, output int n);
      logic p;
      n = 0; p = id_out;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (id_out && !p) n++;
         p = id_out;
      end
   endtask

   task automatic t_id_idle();
      int n, hi;
      len_code = 4'd0; do_reset();
      repeat (10) @(negedge clk);
      count_rises(400, n);
      check(n >= 99 && n <= 101, "R7 idle edge count", n, 100);
      while (id_out) @(negedge clk);
      while (!id_out) @(negedge clk);
      hi = 0;
      while (id_out) begin hi++; @(negedge clk); end
      check(hi == 2, "R7 high time", hi, 2);
   endtask

   task automatic t_id_fix();
      int n;
      len_code = 4'd1; det_sel = 1'b0; do_reset();
      repeat (50) @(negedge clk);
      count_rises(720, n);
      check(n >= 200 && n <= 205, "R8 carries advance output", n, 202);
      do_reset();
      ref_man = 1'b1;
      repeat (50) @(negedge clk);
      count_rises(720, n);
      check(n >= 155 && n <= 160, "R8 borrows delay output", n, 157);
   endtask

   task automatic t_xor();
      bit [1:0] pat [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
      det_sel = 1'b0; len_code = 4'd0; do_reset();
      foreach (pat[k]) begin
         ref_man = pat[k][1]; fb_man = pat[k][0];
         repeat (5) @(negedge clk);
         check(xor_pd == (pat[k][1] ^ pat[k][0]), $sformatf("R9 xor pattern %0d", k),
               int'(xor_pd), int'(pat[k][1] ^ pat[k][0]));
      end
   endtask

   task automatic t_edge();
      len_code = 4'd0; do_reset();
      fb_man = 1'b1; repeat (5) @(negedge clk);
      check(edge_pd == 1'b1, "R10 set by feedback edge", int'(edge_pd), 1);
      ref_man = 1'b1; repeat (5) @(negedge clk);
      check(edge_pd == 1'b0, "R10 cleared by reference edge", int'(edge_pd), 0);
      fb_man = 1'b0; ref_man = 1'b0; repeat (5) @(negedge clk);
      fb_man = 1'b1; repeat (5) @(negedge clk);
      fb_man = 1'b0; repeat (5) @(negedge clk);
      fb_man = 1'b1; ref_man = 1'b1; repeat (5) @(negedge clk);
      check(edge_pd == 1'b0, "R10 tie clears", int'(edge_pd), 0);
   endtask

   task automatic run_loop(input int code, input bit sel, input int limit, output int t_lock);
      int tm [9];
      int nr, good;
      logic p;
      len_code = 4'(code); det_sel = sel; do_reset();
      loop_en = 1'b1; gen_en = 1'b1;
      nr = 0; good = 0; t_lock = -1; p = fb_div;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (fb_div && !p) begin
            for (int k = 0; k < 8; k++) tm[k] = tm[k+1];
            tm[8] = i; nr++;
            if (nr >= 9 && (tm[8] - tm[0]) >= 1002 && (tm[8] - tm[0]) <= 1014) good++;
            else good = 0;
            if (good >= 3) begin t_lock = i; break; end
         end
         p = fb_div;
      end
      loop_en = 1'b0; gen_en = 1'b0;
   endtask

   task automatic t_lock();
      int tx, te, ts;
      run_loop(1, 1'b0, 40000, tx);
      check(tx > 0, "R11 lock with xor comparator", tx, 1);
      run_loop(1, 1'b1, 40000, te);
      check(te > 0, "R11 lock with edge comparator", te, 1);
      run_loop(15, 1'b0, 40000, ts);
      if (ts < 0) ts = 40000;
      check(tx > 0 && ts > tx, "R12 code 15 slower than code 1", ts, tx);
   endtask

   initial begin : watchdog
      wait (cyc >= 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_reset_state();
      t_off();
      for (int c = 1; c <= 4; c++) t_up(c);
      for (int c = 1; c <= 3; c++) t_down(c);
      t_pulse_shape();
      t_code_change();
      t_id_idle();
      t_id_fix();
      t_xor();
      t_edge();
      t_lock();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule